// File: doc/BRIEF.md
# Line-Synchronized Rectified-Sine Current Reference

This block produces the inductor-current reference word for a digitally controlled power-factor-correction boost stage. The shape of the reference does not come from the sampled line voltage. It comes from an internal half-sine table, read by a phase accumulator that advances once per control sample. A digital pulse at each line zero crossing pulls the accumulator back to phase zero. Any distortion on the line voltage therefore never appears in the reference.

Each table sample is scaled by the voltage-loop output and by a fixed multiplier gain. The product saturates at full scale. Both gain words are captured only at half-cycle boundaries, so the amplitude stays flat across each half cycle. If the crossing pulses stop, the accumulator keeps running and wraps by itself at the end of every half cycle. A flag reports that synchronization has been lost.

The default increment gives 100 samples per half cycle, which matches a 50 Hz line sampled at 10 kHz. A multiplier gain of about 3 lets the reference reach full scale at minimum line voltage and full load.

Top module: `pfc_sine_ref`

## Requirements
- R1: While `rstN` is low, and after reset until the first result, `refOut`, `refValid` and `syncLost` are 0. The phase and both held gains reset to 0.
- R2: The table has 256 entries. Entry i = floor(16·p·65535 / (327680 − 4·p)), with p = i·(256 − i). The table index is phase bits [23:16]. Each strobe emits the entry at the current phase, then adds `phaseInc` to the phase modulo 2^24.
- R3: A result equals min(65535, floor(entry · U · K / 2^19)). U is the unsigned Q1.15 gain `unv`, where 0x8000 = 1.0 = full load. K is the unsigned Q4.4 gain `km`, where 0x10 = 1.0.
- R4: A `zeroCross` pulse sets the phase to 0 and captures `unv` and `km`. This happens ahead of a strobe in the same cycle, so that strobe emits entry 0 using the newly captured gains.
- R5: Changes on `unv` and `km` have no effect between boundaries. The held gains change only on `zeroCross`, or when a strobe carries the phase past 2^24. A wrap-captured gain applies from the next strobe onward. Before the first boundary both gains are 0.
- R6: `refValid` is high in exactly the second cycle after each cycle in which `sampleStb` is high. `refOut` changes only when `refValid` rises with it.
- R7: The increments accumulated since the last `zeroCross` (or reset) saturate at 5·2^22, which is 1.25 half cycles. `syncLost` goes high once that limit is reached. It is cleared on the cycle after a `zeroCross`.
- R8: A product above 65535 gives a result of exactly 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleStb | input | 1 | One-cycle control-sample strobe |
| zeroCross | input | 1 | One-cycle line zero-crossing pulse |
| phaseInc | input | 24 | Phase increment per sample |
| unv | input | 16 | Voltage-loop output, unsigned Q1.15 |
| km | input | 8 | Multiplier gain, unsigned Q4.4 |
| refOut | output | 16 | Current reference, saturated |
| refValid | output | 1 | Result strobe |
| syncLost | output | 1 | No zero crossing seen within 1.25 half cycles |

## Verification
A wrong phase value appears at the next result as a wrong table entry. A lost or misplaced phase reset appears as a nonzero first sample after a crossing, two cycles after the strobe. A held gain that is captured at the wrong moment shows up as a step in amplitude part-way through a half cycle, on the very next result. A wrong elapsed count moves the rising edge of `syncLost` away from sample 126 without crossings at the default increment. The cycle-by-cycle comparison therefore catches each of these faults within two cycles of the strobe that exposes it.

// File: rtl/pfc_ref_pkg.sv
package pfc_ref_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic sampleGo;   // emit a table sample this cycle
    logic takeLive;   // sample uses live gains (crossing this cycle)
    logic latchGain;  // held gains capture live gains at this edge
  } ctlStrobes_t;

endpackage

// File: rtl/pfc_ref_ctrl.sv
module pfc_ref_ctrl
  import pfc_ref_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int LUT_AW  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleStb,
  input  logic               zeroCross,
  input  logic [PHASE_W-1:0] phaseInc,
  output ctlStrobes_t        ctl,
  output logic [LUT_AW-1:0]  lutIndex,
  output logic               syncLost
);

  localparam int EL_W = PHASE_W + 2;
  // 1.25 half cycles in phase units
  localparam logic [EL_W-1:0] LOST_LIMIT = EL_W'(5) << (PHASE_W - 2);

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] phaseNow;
  logic [PHASE_W:0]   phaseSum;
  logic               phaseCarry;

  logic [EL_W-1:0]    elapsed;
  logic [EL_W-1:0]    elBase;
  logic [EL_W:0]      elAdd;
  logic [EL_W-1:0]    elNext;

  // Crossing resets the phase ahead of any same-cycle sample
  always_comb begin
    phaseNow   = zeroCross ? '0 : phase;
    phaseSum   = {1'b0, phaseNow} + {1'b0, phaseInc};
    phaseCarry = phaseSum[PHASE_W];
    lutIndex   = phaseNow[PHASE_W-1 -: LUT_AW];
  end

  always_comb begin
    ctl.sampleGo  = sampleStb;
    ctl.takeLive  = zeroCross;
    ctl.latchGain = zeroCross | (sampleStb & phaseCarry);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (sampleStb) begin
      phase <= phaseSum[PHASE_W-1:0];
    end else begin
      phase <= phaseNow;
    end
  end

  // Elapsed-phase watchdog, saturating at the loss limit
  always_comb begin
    elBase = zeroCross ? '0 : elapsed;
    elAdd  = {1'b0, elBase} + (EL_W+1)'(phaseInc);
    if (!sampleStb) begin
      elNext = elBase;
    end else if (elAdd >= {1'b0, LOST_LIMIT}) begin
      elNext = LOST_LIMIT;
    end else begin
      elNext = elAdd[EL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed  <= '0;
      syncLost <= 1'b0;
    end else begin
      elapsed  <= elNext;
      syncLost <= (elNext >= LOST_LIMIT);
    end
  end

endmodule

// File: rtl/pfc_ref_datapath.sv
module pfc_ref_datapath
  import pfc_ref_pkg::*;
#(
  parameter int LUT_AW   = 8,
  parameter int LUT_DW   = 16,
  parameter int UNV_W    = 16,
  parameter int UNV_FRAC = 15,
  parameter int KM_W     = 8,
  parameter int KM_FRAC  = 4,
  parameter int OUT_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [LUT_AW-1:0] lutIndex,
  input  logic [UNV_W-1:0]  unv,
  input  logic [KM_W-1:0]   km,
  output logic [OUT_W-1:0]  refOut,
  output logic              refValid
);

  localparam int    LUT_DEPTH = 1 << LUT_AW;
  localparam int    PROD_W    = LUT_DW + UNV_W + KM_W;
  localparam int    SHIFT     = UNV_FRAC + KM_FRAC;
  localparam longint FULL     = (longint'(1) << LUT_DW) - 1;

  // Rational half-sine approximation, exact 0 at the ends and FULL at mid
  function automatic logic [LUT_DW-1:0] halfSine(input int idx);
    longint p, num, den;
    p   = longint'(idx) * longint'(LUT_DEPTH - idx);
    num = 64'sd16 * p * FULL;
    den = 64'sd5 * longint'(LUT_DEPTH) * longint'(LUT_DEPTH) - 64'sd4 * p;
    return LUT_DW'(num / den);
  endfunction

  logic [LUT_DW-1:0] romTbl [LUT_DEPTH];

  for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_rom
    assign romTbl[g] = halfSine(g);
  end

  logic [UNV_W-1:0]  unvHeld;
  logic [KM_W-1:0]   kmHeld;
  logic              s1Valid;
  logic [LUT_DW-1:0] s1Lut;
  logic [UNV_W-1:0]  s1Unv;
  logic [KM_W-1:0]   s1Km;

  // Gains change only at half-cycle boundaries
  always_ff @(posedge clk) begin
    if (!rstN) begin
      unvHeld <= '0;
      kmHeld  <= '0;
    end else if (ctl.latchGain) begin
      unvHeld <= unv;
      kmHeld  <= km;
    end
  end

  // Stage 1: table read and gain capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Lut   <= '0;
      s1Unv   <= '0;
      s1Km    <= '0;
    end else begin
      s1Valid <= ctl.sampleGo;
      if (ctl.sampleGo) begin
        s1Lut <= romTbl[lutIndex];
        s1Unv <= ctl.takeLive ? unv : unvHeld;
        s1Km  <= ctl.takeLive ? km  : kmHeld;
      end
    end
  end

  logic [PROD_W-1:0] prodFull;
  logic [PROD_W-1:0] prodScaled;
  logic              prodOver;

  always_comb begin
    prodFull   = PROD_W'(s1Lut) * PROD_W'(s1Unv) * PROD_W'(s1Km);
    prodScaled = prodFull >> SHIFT;
    prodOver   = |prodScaled[PROD_W-1:OUT_W];
  end

  // Stage 2: saturate and present
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refOut   <= '0;
      refValid <= 1'b0;
    end else begin
      refValid <= s1Valid;
      if (s1Valid) begin
        refOut <= prodOver ? {OUT_W{1'b1}} : prodScaled[OUT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/pfc_sine_ref.sv
module pfc_sine_ref
  import pfc_ref_pkg::*;
#(
  parameter int PHASE_W  = 24,
  parameter int LUT_AW   = 8,
  parameter int LUT_DW   = 16,
  parameter int UNV_W    = 16,
  parameter int UNV_FRAC = 15,
  parameter int KM_W     = 8,
  parameter int KM_FRAC  = 4,
  parameter int OUT_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleStb,
  input  logic               zeroCross,
  input  logic [PHASE_W-1:0] phaseInc,
  input  logic [UNV_W-1:0]   unv,
  input  logic [KM_W-1:0]    km,
  output logic [OUT_W-1:0]   refOut,
  output logic               refValid,
  output logic               syncLost
);

  ctlStrobes_t       ctl;
  logic [LUT_AW-1:0] lutIndex;

  pfc_ref_ctrl #(
    .PHASE_W (PHASE_W),
    .LUT_AW  (LUT_AW)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleStb (sampleStb),
    .zeroCross (zeroCross),
    .phaseInc  (phaseInc),
    .ctl       (ctl),
    .lutIndex  (lutIndex),
    .syncLost  (syncLost)
  );

  pfc_ref_datapath #(
    .LUT_AW   (LUT_AW),
    .LUT_DW   (LUT_DW),
    .UNV_W    (UNV_W),
    .UNV_FRAC (UNV_FRAC),
    .KM_W     (KM_W),
    .KM_FRAC  (KM_FRAC),
    .OUT_W    (OUT_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .lutIndex (lutIndex),
    .unv      (unv),
    .km       (km),
    .refOut   (refOut),
    .refValid (refValid)
  );

endmodule

// File: rtl/pfc_ref_checker.sv
module pfc_ref_checker #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleStb,
  input logic             zeroCross,
  input logic [OUT_W-1:0] refOut,
  input logic             refValid,
  input logic             syncLost
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> ##2 refValid);                                    // R6

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    refValid |-> $past(sampleStb, 2));                              // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !refValid |-> $stable(refOut));                                 // R6

  AST_ZC_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (zeroCross && sampleStb) |-> ##2 (refOut == '0));               // R4

  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    zeroCross |=> !syncLost);                                       // R7

  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (syncLost && !zeroCross) |=> syncLost);                         // R7

endmodule

bind pfc_sine_ref pfc_ref_checker #(.OUT_W(OUT_W)) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .sampleStb (sampleStb),
  .zeroCross (zeroCross),
  .refOut    (refOut),
  .refValid  (refValid),
  .syncLost  (syncLost)
);

// File: tb/test_pfc_sine_ref.sv
`timescale 1ns/1ps
module test_pfc_sine_ref;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStb = 1'b0;
  logic        zeroCross = 1'b0;
  logic [23:0] phaseInc = 24'd0;
  logic [15:0] unv = 16'd0;
  logic [7:0]  km = 8'd0;
  logic [15:0] refOut;
  logic        refValid;
  logic        syncLost;

  always #5 clk = ~clk;

  pfc_sine_ref i_pfc_sine_ref (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .zeroCross(zeroCross),
    .phaseInc(phaseInc), .unv(unv), .km(km),
    .refOut(refOut), .refValid(refValid), .syncLost(syncLost)
  );

  int    checks = 0;
  int    errors = 0;
  int    strobes = 0;
  int    valids = 0;
  bit    compareOn = 1'b0;
  bit    sawSat = 1'b0;
  bit    done = 1'b0;
  string curReq = "R2";

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R2 table from its stated formula
  function automatic longint sineRef(input longint i);
    longint p;
    p = i * (256 - i);
    return (16 * p * 65535) / (327680 - 4 * p);
  endfunction

  localparam longint TWO24 = 64'd16777216;
  localparam longint LIMIT = 64'd20971520;

  // Behavioural reference model
  longint mPhase, mEl, mUnvH, mKmH, mS1l, mS1u, mS1k, mOut;
  bit     mLost, mS1v, mVal;

  always @(posedge clk) begin
    longint ph, u, k, sum, prod;
    bit     wrap;
    if (!rstN) begin
      mPhase = 0; mEl = 0; mUnvH = 0; mKmH = 0; mS1l = 0; mS1u = 0; mS1k = 0;
      mOut = 0; mLost = 0; mS1v = 0; mVal = 0;
    end else begin
      mVal = mS1v;
      if (mS1v) begin
        prod = (mS1l * mS1u * mS1k) >> 19;
        mOut = (prod > 65535) ? 65535 : prod;
      end
      ph = zeroCross ? 0 : mPhase;
      u  = zeroCross ? longint'(unv) : mUnvH;
      k  = zeroCross ? longint'(km)  : mKmH;
      mS1v = sampleStb;
      wrap = 1'b0;
      if (sampleStb) begin
        mS1l = sineRef(ph >> 16);
        mS1u = u;
        mS1k = k;
        sum  = ph + longint'(phaseInc);
        wrap = (sum >= TWO24);
        ph   = sum % TWO24;
      end
      mPhase = ph;
      if (zeroCross || wrap) begin
        mUnvH = longint'(unv);
        mKmH  = longint'(km);
      end
      if (zeroCross) mEl = 0;
      if (sampleStb) begin
        mEl = mEl + longint'(phaseInc);
        if (mEl > LIMIT) mEl = LIMIT;
      end
      mLost = (mEl >= LIMIT);
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (compareOn && !done) begin
      chk("R6", longint'(refValid), longint'(mVal));
      chk("R7", longint'(syncLost), longint'(mLost));
      chk(curReq, longint'(refOut), mOut);
      if (refValid) valids++;
      if (refValid && refOut == 16'hFFFF) sawSat = 1'b1;
    end
  end

  // Called at a negedge; returns at a negedge
  task automatic sample(input bit zc);
    sampleStb = 1'b1;
    zeroCross = zc;
    strobes++;
    @(negedge clk);
    sampleStb = 1'b0;
    zeroCross = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseZc();
    zeroCross = 1'b1;
    @(negedge clk);
    zeroCross = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", longint'(refOut), 0);
    chk("R1", longint'(refValid), 0);
    chk("R1", longint'(syncLost), 0);
    rstN = 1'b1;
    @(negedge clk);
    compareOn = 1'b1;
    chk("R1", longint'(refOut), 0);

    // R5: gains are zero until the first boundary
    phaseInc = 24'd167772;
    unv = 16'h8000;
    km  = 8'h10;
    curReq = "R5";
    for (int i = 0; i < 20; i++) sample(1'b0);
    chk("R5", longint'(refOut), 0);

    // R2/R3: two synchronized half cycles, unity gains
    curReq = "R2";
    for (int h = 0; h < 2; h++) begin
      pulseZc();
      for (int i = 0; i < 100; i++) sample(1'b0);
    end

    // R5: mid-cycle gain change ignored until the crossing
    curReq = "R5";
    pulseZc();
    for (int i = 0; i < 50; i++) sample(1'b0);
    unv = 16'h4000;
    km  = 8'h08;
    sample(1'b0);
    // entry at phase 50*167772 (index 127) with unity gains
    chk("R5", longint'(refOut), sineRef((50 * 167772) >> 16));
    for (int i = 0; i < 49; i++) sample(1'b0);

    // R3: non-unity gains after a crossing
    curReq = "R3";
    pulseZc();
    for (int i = 0; i < 100; i++) sample(1'b0);

    // R8: gain of 3 saturates near the crest
    curReq = "R8";
    unv = 16'h8000;
    km  = 8'h30;
    pulseZc();
    for (int i = 0; i < 100; i++) sample(1'b0);
    chk("R8", longint'(sawSat), 1);

    // R7/R5: crossings stop; self wrap captures gains; loss after 126 samples
    curReq = "R7";
    km = 8'h10;
    pulseZc();
    for (int i = 0; i < 60; i++) sample(1'b0);
    unv = 16'h6000;
    for (int i = 0; i < 65; i++) sample(1'b0);
    chk("R7", longint'(syncLost), 0);
    sample(1'b0);
    chk("R7", longint'(syncLost), 1);
    for (int i = 0; i < 20; i++) sample(1'b0);

    // R4: crossing together with a strobe emits entry 0 and clears the flag
    curReq = "R4";
    sample(1'b1);
    chk("R4", longint'(refOut), 0);
    chk("R7", longint'(syncLost), 0);
    for (int i = 0; i < 10; i++) sample(1'b0);

    // R6: back-to-back strobes with a large increment
    curReq = "R6";
    phaseInc = 24'd1000000;
    for (int i = 0; i < 30; i++) begin
      sampleStb = 1'b1;
      strobes++;
      @(negedge clk);
    end
    sampleStb = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6", longint'(valids), longint'(strobes));

    finishRun();
  end

endmodule